// File: doc/BRIEF.md
# Output-Port Merge Tree with Cut-Through

This block is the fabric slice for a single output port of an N-input cell switch. Every input owns one small crosspoint buffer (a leaf) that holds cells bound for this output. The leaves feed a binary tree of bounded two-into-one merge buffers. The root of the tree is the only part that drives the output port, so a cell leaving the root never contends with anything. Each accepted cell is stamped with an arrival counter. Every merge node forwards the older of its two candidate heads. The output port therefore sees one FIFO in global arrival order, as if the switch were output-queued.

Every link between tree levels carries three signals: a valid bit, a ready bit and a subtree-empty bit. A node whose own buffer is empty passes the winning child head straight to its parent in the same cycle. A cell entering an idle tree thus reaches the output one clock after it is accepted, and does not spend one clock per level. A node never picks a cell while a non-empty child has not yet presented its head. This stops a younger cell from overtaking an older one.

Both data edges are valid/ready streams. An input cell moves on a rising edge where `in_valid[i]` and `in_ready[i]` are both high. `in_ready[i]` depends only on the leaf's registered occupancy. The output cell moves on an edge where `out_valid` and `out_ready` are both high. Once `out_valid` is high, the cell is held unchanged until it is taken. Dropping `out_ready` back-pressures the tree level by level, up to the inputs.

Top module: `mot_merge_tree`

## Requirements
- R1: After reset, `out_valid` is low and every `in_ready` bit is high.
- R2: `in_ready[i]` is high exactly when leaf i has a free slot. While `out_ready` stays low and only input i sends, the path from that input absorbs D*(log2(N)+1) cells before `in_ready[i]` drops. The other inputs stay ready.
- R3: Cells leave in the order of the rising edges on which they were accepted. Cells accepted on the same edge leave in ascending input index (index 0 first).
- R4: `out_valid` is high on every cycle in which the block holds at least one cell. A cell accepted into an empty block is presented on `out_data` right after that edge.
- R5: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and `out_data` is unchanged.
- R6: Under any pattern of input traffic and output back-pressure, every accepted cell leaves exactly once. No cell is lost, altered or duplicated.
- R7: The arrival stamp advances by one on each edge where at least one cell is accepted. It is clog2((2N-1)*D)+2 bits wide and compared modulo its range, so ordering stays correct as it wraps.
- R8: No buffer takes a cell while full unless its head leaves on the same edge. No buffer is popped while empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input cell offered |
| in_ready | output | N | Per-input leaf has a free slot |
| in_data | input | N*W | Per-input payloads; input i in bits [i*W +: W] |
| out_valid | output | 1 | Output cell presented |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_data | output | W | Output cell payload |

## Verification
The bench builds the block with N=4, D=2 and a 16-bit payload. The payload carries the source index and a per-source sequence number, so every cell is unique and order errors can be seen directly. With four leaves the tree has two levels of merge nodes. This exercises both the ties between sibling leaves and those between subtrees, and a path capacity of six cells that is easy to fill. The stamp is only six bits wide, so a long random run wraps it hundreds of times under random back-pressure.

// File: rtl/mot_pkg.sv
package mot_pkg;

  // total number of cell slots in one output tree: N leaves plus N-1 merge nodes
  function automatic int tree_cap(input int n, input int d);
    return (2 * n - 1) * d;
  endfunction

  // stamp width: two bits of headroom over the span of stamps the tree can hold
  function automatic int stamp_bits(input int n, input int d);
    return $clog2(tree_cap(n, d)) + 2;
  endfunction

endpackage

// File: rtl/mot_fifo.sv
module mot_fifo #(
  parameter int W = 32,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] head
);
  localparam int PW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(D - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(D));
  assign empty = (cnt == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |-> pop);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/mot_merge_node.sv
module mot_merge_node #(
  parameter int W   = 32,
  parameter int TSW = 8,
  parameter int D   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           a_valid,
  input  logic           a_empty,
  input  logic [TSW-1:0] a_ts,
  input  logic [W-1:0]   a_data,
  output logic           a_ready,
  input  logic           b_valid,
  input  logic           b_empty,
  input  logic [TSW-1:0] b_ts,
  input  logic [W-1:0]   b_data,
  output logic           b_ready,
  output logic           o_valid,
  output logic           o_empty,
  output logic [TSW-1:0] o_ts,
  output logic [W-1:0]   o_data,
  input  logic           o_ready
);
  localparam int EW = TSW + W;

  // x is not younger than y, modulo the stamp range
  function automatic logic ts_le(input logic [TSW-1:0] x, input logic [TSW-1:0] y);
    logic [TSW-1:0] diff;
    diff = x - y;
    return diff[TSW-1] || (diff == '0);
  endfunction

  logic          take_a, take_b, sel_valid;
  logic [EW-1:0] sel_entry, q_head;
  logic          q_full, q_empty, q_push, q_pop;
  logic          bypass, can_push, fwd;

  // a child may be passed over only when its whole subtree is empty
  always_comb begin
    take_a    = a_valid && (b_empty || (b_valid && ts_le(a_ts, b_ts)));
    take_b    = !take_a && b_valid && (a_empty || a_valid);
    sel_valid = take_a || take_b;
    sel_entry = take_a ? {a_ts, a_data} : {b_ts, b_data};
  end

  assign q_pop    = !q_empty && o_ready;
  assign bypass   = q_empty && o_ready;
  assign can_push = !q_full || q_pop;
  assign q_push   = sel_valid && !bypass && can_push;
  assign fwd      = bypass || can_push;
  assign a_ready  = take_a && fwd;
  assign b_ready  = take_b && fwd;

  mot_fifo #(.W(EW), .D(D)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_data(sel_entry),
    .pop      (q_pop),
    .full     (q_full),
    .empty    (q_empty),
    .head     (q_head)
  );

  assign o_valid         = !q_empty || sel_valid;
  assign {o_ts, o_data}  = q_empty ? sel_entry : q_head;
  assign o_empty         = q_empty && a_empty && b_empty;

  // departure-order tracking for the ordering check
  logic           seen;
  logic [TSW-1:0] last_ts;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_ts <= '0;
    end else if (o_valid && o_ready) begin
      seen    <= 1'b1;
      last_ts <= o_ts;
    end else if (o_empty) begin
      seen    <= 1'b0;
    end
  end

  // R3
  order_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_ready && seen |-> ts_le(last_ts, o_ts));

  // R4
  head_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_empty && b_empty) |-> o_valid);

endmodule

// File: rtl/mot_merge_tree.sv
module mot_merge_tree #(
  parameter int N = 8,
  parameter int D = 2,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  output logic [N-1:0]   in_ready,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);
  localparam int TSW = mot_pkg::stamp_bits(N, D);
  localparam int EW  = TSW + W;
  localparam int NL  = 2 * N - 1;

  // heap numbering: node k has children 2k and 2k+1; leaf i sits at N+i
  logic           lk_valid [1:NL];
  logic           lk_ready [1:NL];
  logic           lk_empty [1:NL];
  logic [TSW-1:0] lk_ts    [1:NL];
  logic [W-1:0]   lk_data  [1:NL];

  // arrival stamp: advances once per edge with any acceptance (R7)
  logic [TSW-1:0] stamp_q;
  logic           any_arrival;
  assign any_arrival = |(in_valid & in_ready);

  always_ff @(posedge clk) begin
    if (!rst_n)           stamp_q <= '0;
    else if (any_arrival) stamp_q <= stamp_q + TSW'(1);
  end

  for (genvar i = 0; i < N; i++) begin : g_leaf
    logic          l_full, l_empty;
    logic [EW-1:0] l_head;

    mot_fifo #(.W(EW), .D(D)) u_leaf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (in_valid[i] && in_ready[i]),
      .push_data({stamp_q, in_data[i*W +: W]}),
      .pop      (lk_valid[N+i] && lk_ready[N+i]),
      .full     (l_full),
      .empty    (l_empty),
      .head     (l_head)
    );

    assign in_ready[i]   = !l_full;
    assign lk_valid[N+i] = !l_empty;
    assign lk_empty[N+i] = l_empty;
    assign lk_ts[N+i]    = l_head[EW-1:W];
    assign lk_data[N+i]  = l_head[W-1:0];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    mot_merge_node #(.W(W), .TSW(TSW), .D(D)) u_node (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_valid(lk_valid[2*k]),
      .a_empty(lk_empty[2*k]),
      .a_ts   (lk_ts[2*k]),
      .a_data (lk_data[2*k]),
      .a_ready(lk_ready[2*k]),
      .b_valid(lk_valid[2*k+1]),
      .b_empty(lk_empty[2*k+1]),
      .b_ts   (lk_ts[2*k+1]),
      .b_data (lk_data[2*k+1]),
      .b_ready(lk_ready[2*k+1]),
      .o_valid(lk_valid[k]),
      .o_empty(lk_empty[k]),
      .o_ts   (lk_ts[k]),
      .o_data (lk_data[k]),
      .o_ready(lk_ready[k])
    );
  end

  assign out_valid   = lk_valid[1];
  assign out_data    = lk_data[1];
  assign lk_ready[1] = out_ready;

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && (out_data == $past(out_data)));

endmodule

// File: tb/sim_mot_merge_tree.sv
`timescale 1ns/1ps
module sim_mot_merge_tree;
  localparam int N = 4;
  localparam int D = 2;
  localparam int W = 16;
  localparam int PATH_CAP = D * ($clog2(N) + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N-1:0]   in_ready;
  logic [N*W-1:0] in_data = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [W-1:0]   out_data;

  always #2 clk = ~clk;

  mot_merge_tree #(.N(N), .D(D), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int rcvd = 0;
  int arr_cycles = 0;
  int acc0 = 0;
  int seq [N];
  logic [W-1:0] exp_q [$];
  logic prev_stall = 1'b0;
  logic [W-1:0] prev_data = '0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: compare against the model, drive new inputs, then update the model
  task automatic cycle(input logic [N-1:0] v, input logic ordy);
    @(negedge clk);
    // R4: presence of any held cell means a cell is presented
    check(out_valid == (exp_q.size() > 0), "R4", int'(out_valid), int'(exp_q.size() > 0));
    // R3 / R6: head of output equals oldest outstanding cell
    if (out_valid && exp_q.size() > 0)
      check(out_data == exp_q[0], "R3", int'(out_data), int'(exp_q[0]));
    // R5: stalled cell held
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R5", int'(out_data), int'(prev_data));
    in_valid  = v;
    out_ready = ordy;
    for (int i = 0; i < N; i++)
      in_data[i*W +: W] = {2'(i), 14'(seq[i])};
    #1;
    if (out_valid && out_ready) begin
      void'(exp_q.pop_front());
      rcvd++;
    end
    if (|(in_valid & in_ready)) arr_cycles++;
    for (int i = 0; i < N; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        exp_q.push_back({2'(i), 14'(seq[i])});
        seq[i]++;
        sent++;
        if (i == 0) acc0++;
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  endtask

  initial begin
    for (int i = 0; i < N; i++) seq[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == '1, "R1", int'(in_ready), int'({N{1'b1}}));

    // R4: single cell on an idle tree appears after one edge (checked in next cycle)
    cycle(4'b0100, 1'b0);
    cycle(4'b0000, 1'b0);
    cycle(4'b0000, 1'b1);
    repeat (4) cycle(4'b0000, 1'b1);

    // R2: path capacity from input 0 with the output stalled
    acc0 = 0;
    repeat (20) cycle(4'b0001, 1'b0);
    check(acc0 == PATH_CAP, "R2", acc0, PATH_CAP);
    check(in_ready[0] == 1'b0, "R2", int'(in_ready[0]), 0);
    check(in_ready[1] == 1'b1, "R2", int'(in_ready[1]), 1);
    repeat (20) cycle(4'b0000, 1'b1);

    // R3: same-edge arrivals, tie broken by ascending index
    cycle(4'b1111, 1'b1);
    repeat (10) cycle(4'b0000, 1'b1);
    cycle(4'b1010, 1'b0);
    cycle(4'b0101, 1'b0);
    repeat (10) cycle(4'b0000, 1'b1);

    // R6 / R7: random traffic and back-pressure, long enough to wrap the stamp
    for (int c = 0; c < 20000; c++) begin
      logic [N-1:0] v;
      logic r;
      v = N'($urandom);
      if ((c / 500) % 3 == 2) r = ($urandom_range(0, 3) == 0);
      else                    r = ($urandom_range(0, 3) != 0);
      cycle(v, r);
    end
    repeat (60) cycle(4'b0000, 1'b1);

    // R6: everything accepted has left exactly once
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    check(rcvd == sent, "R6", rcvd, sent);
    check(out_valid == 1'b0, "R6", int'(out_valid), 0);
    // R7: stamp range (64 values) wrapped many times during the run
    check(arr_cycles > 640, "R7", arr_cycles, 641);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule